// File: doc/BRIEF.md
# Deferred Condition Code Evaluator

This block lets an integer pipeline postpone flag work. When an arithmetic, logic, compare or shift operation retires, the datapath records only three things: an operation class code, the result word and the source operand. Nothing is computed at that point. When a consumer later needs the flags (a branch, a status read, a context save), it pulses an evaluate strobe. The block then rebuilds N, Z, V and C from the stored words, using the rules of the recorded class.

Carry and overflow are recovered after the fact. The block recomputes the missing operand from the result and the source, at the width of the operation. Byte and word compares are evaluated at 8 and 16 bits.

A successful evaluation rewrites the stored class to the pass-through class and stores the flag nibble as the new result word. Any later evaluation then returns the same flags. Undefined class codes raise a one-cycle illegal indication and disturb nothing.

Top module: `cc_eval`

## Requirements
- R1: After reset, flags_o is 0, illegal_o is 0, and the stored state is class PASS (code 0) with result 0. An evaluation straight after reset therefore yields NZVC = 0000.
- R2: Class LOGIC (code 1) sets N and Z from the 32-bit result and clears V and C. The nibble bit order is N=3, Z=2, V=1, C=0.
- R3: Z is set when the result is zero at the operation width. N is set only when the result is nonzero and its top bit at that width is 1. The width is 8 bits for CMPB, 16 bits for CMPW and 32 bits for every other class. N and Z are never both set.
- R4: Class ADD (code 2) sets C when result < source (unsigned). V is bit 31 of (src ^ res) & ~(t ^ src), where t = res - src.
- R5: Classes SUB (code 3), CMPB (code 4) and CMPW (code 5) work at 32, 8 and 16 bits. They form t = res + src at that width. C is set when t < src, and V is the top bit at that width of (t ^ res) & (t ^ src).
- R6: Class ADDX (code 6) sets C when res <= src. V is taken as for ADD, but with t = res - src - 1.
- R7: Class SUBX (code 7) forms t = res + src + 1. C is set when t <= src, and V is bit 31 of (t ^ res) & (t ^ src).
- R8: Class SHIFT (code 8) takes N and Z from the result, sets C when the stored source word is nonzero, and clears V.
- R9: For ADDX and SUBX the new Z is ANDed with prev_z_i. A Z that was clear stays clear.
- R10: Codes 9 to 15 are illegal. Evaluating one pulses illegal_o for one cycle, leaves flags_o unchanged and leaves the stored state unchanged, so a repeat evaluation is illegal again.
- R11: Class PASS (code 0) outputs the low four bits of the stored result unchanged. A legal evaluation rewrites the stored state to PASS with the flag nibble as the result, so evaluating again returns the same NZVC.
- R12: flags_o is {X, N, Z, V, C} in bits 4..0. It updates on the clock edge that samples eval_i, with X taken from x_i at that edge, and it holds between evaluations.
- R13: When rec_valid_i and eval_i are high together, the record is stored and the evaluation is dropped: flags_o holds and illegal_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Store class, result and source |
| rec_op_i | input | 4 | Operation class code to store |
| rec_dest_i | input | 32 | Result word to store |
| rec_src_i | input | 32 | Source operand to store |
| eval_i | input | 1 | Evaluate the stored state |
| x_i | input | 1 | Current extend bit, copied into flags_o[4] |
| prev_z_i | input | 1 | Previous Z flag, used by the sticky rule |
| flags_o | output | 5 | {X, N, Z, V, C} from the last legal evaluation |
| illegal_o | output | 1 | One-cycle pulse after evaluating an undefined code |

## Verification
The checker watches every cycle for the properties that hold no matter what the data is:
- N and Z are never both set after a non-pass evaluation.
- LOGIC yields clear V and C, and SHIFT yields clear V.
- The stored class returns to PASS after every legal evaluation.
- X follows x_i.
- flags_o holds whenever illegal_o is high or a record collides with an evaluation.

The exact carry and overflow values depend on the data, so only the bench's directed scenarios can show them. These include the per-width compares, the extended variants with the sticky Z rule, and the signed and unsigned boundary operands.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    CC_PASS  = 4'd0,
    CC_LOGIC = 4'd1,
    CC_ADD   = 4'd2,
    CC_SUB   = 4'd3,
    CC_CMPB  = 4'd4,
    CC_CMPW  = 4'd5,
    CC_ADDX  = 4'd6,
    CC_SUBX  = 4'd7,
    CC_SHIFT = 4'd8
  } cc_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_nzvc_t;
endpackage

// File: rtl/cc_width_calc.sv
// N/Z and subtract-style C/V rebuilt at one operand width
module cc_width_calc #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] dest_i,
  input  logic [WIDTH-1:0] src_i,
  output logic             z_o,
  output logic             n_o,
  output logic             sub_c_o,
  output logic             sub_v_o
);
  logic [WIDTH-1:0] orig;
  logic [WIDTH-1:0] ovf_vec;

  always_comb begin
    z_o     = (dest_i == '0);
    n_o     = !z_o && dest_i[WIDTH-1];
    orig    = dest_i + src_i;          // minuend recovered from difference
    sub_c_o = (orig < src_i);
    ovf_vec = (orig ^ dest_i) & (orig ^ src_i);
    sub_v_o = ovf_vec[WIDTH-1];
  end
endmodule

// File: rtl/cc_flag_logic.sv
module cc_flag_logic
  import cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] dest_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              prev_z_i,
  output cc_nzvc_t          nzvc_o,
  output logic              legal_o
);
  localparam int NUM_W = 3;   // byte, word, full

  logic [NUM_W-1:0] w_z, w_n, w_c, w_v;

  for (genvar g = 0; g < NUM_W; g++) begin : g_width
    localparam int WW = DATA_W >> (NUM_W - 1 - g);
    cc_width_calc #(.WIDTH(WW)) u_calc (
      .dest_i (dest_i[WW-1:0]),
      .src_i  (src_i[WW-1:0]),
      .z_o    (w_z[g]),
      .n_o    (w_n[g]),
      .sub_c_o(w_c[g]),
      .sub_v_o(w_v[g])
    );
  end

  logic [1:0]        sel;
  logic [DATA_W-1:0] add_t, addx_t, subx_t;
  logic [DATA_W-1:0] add_vv, addx_vv, subx_vv;

  always_comb begin
    unique case (op_i)
      CC_CMPB: sel = 2'd0;
      CC_CMPW: sel = 2'd1;
      default: sel = 2'd2;
    endcase
    add_t   = dest_i - src_i;
    addx_t  = dest_i - src_i - 1'b1;
    subx_t  = dest_i + src_i + 1'b1;
    add_vv  = (src_i ^ dest_i) & ~(add_t ^ src_i);
    addx_vv = (src_i ^ dest_i) & ~(addx_t ^ src_i);
    subx_vv = (subx_t ^ dest_i) & (subx_t ^ src_i);
  end

  always_comb begin
    legal_o  = 1'b1;
    nzvc_o.n = w_n[sel];
    nzvc_o.z = w_z[sel];
    nzvc_o.v = 1'b0;
    nzvc_o.c = 1'b0;
    case (op_i)
      CC_PASS:  nzvc_o = cc_nzvc_t'(dest_i[3:0]);
      CC_LOGIC: ;
      CC_ADD: begin
        nzvc_o.c = (dest_i < src_i);
        nzvc_o.v = add_vv[DATA_W-1];
      end
      CC_SUB, CC_CMPB, CC_CMPW: begin
        nzvc_o.c = w_c[sel];
        nzvc_o.v = w_v[sel];
      end
      CC_ADDX: begin
        nzvc_o.c = (dest_i <= src_i);
        nzvc_o.v = addx_vv[DATA_W-1];
        nzvc_o.z = w_z[sel] & prev_z_i;   // sticky clear Z
      end
      CC_SUBX: begin
        nzvc_o.c = (subx_t <= src_i);
        nzvc_o.v = subx_vv[DATA_W-1];
        nzvc_o.z = w_z[sel] & prev_z_i;
      end
      CC_SHIFT: nzvc_o.c = (src_i != '0);
      default: begin
        legal_o = 1'b0;
        nzvc_o  = '0;
      end
    endcase
  end
endmodule

// File: rtl/cc_eval.sv
module cc_eval
  import cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_valid_i,
  input  logic [OP_W-1:0]   rec_op_i,
  input  logic [DATA_W-1:0] rec_dest_i,
  input  logic [DATA_W-1:0] rec_src_i,
  input  logic              eval_i,
  input  logic              x_i,
  input  logic              prev_z_i,
  output logic [4:0]        flags_o,
  output logic              illegal_o
);
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] dest_q, src_q;
  logic [4:0]        flags_q;
  logic              illegal_q;
  cc_nzvc_t          nzvc;
  logic              legal;

  cc_flag_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i    (op_q),
    .dest_i  (dest_q),
    .src_i   (src_q),
    .prev_z_i(prev_z_i),
    .nzvc_o  (nzvc),
    .legal_o (legal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= CC_PASS;
      dest_q    <= '0;
      src_q     <= '0;
      flags_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= 1'b0;
      if (rec_valid_i) begin
        op_q   <= rec_op_i;
        dest_q <= rec_dest_i;
        src_q  <= rec_src_i;
      end else if (eval_i) begin
        if (legal) begin
          op_q    <= CC_PASS;
          dest_q  <= {{(DATA_W-4){1'b0}}, nzvc};
          flags_q <= {x_i, nzvc};
        end else begin
          illegal_q <= 1'b1;
        end
      end
    end
  end

  assign flags_o   = flags_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/cc_eval_chk.sv
module cc_eval_chk
  import cc_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rec_valid_i,
  input logic            eval_i,
  input logic            x_i,
  input logic [4:0]      flags_o,
  input logic            illegal_o,
  input logic [OP_W-1:0] op_q
);
  logic do_eval, op_legal;
  assign do_eval  = eval_i && !rec_valid_i;
  assign op_legal = (op_q <= CC_SHIFT);

  AST_NZ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_eval && op_legal && op_q != CC_PASS) |=> !(flags_o[3] && flags_o[2])); // R3
  AST_LOGIC_CV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_eval && op_q == CC_LOGIC) |=> flags_o[1:0] == 2'b00); // R2
  AST_SHIFT_V_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_eval && op_q == CC_SHIFT) |=> !flags_o[1]); // R8
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $stable(flags_o)); // R10
  AST_REWRITE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_eval && op_legal) |=> op_q == CC_PASS); // R11
  AST_X_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_eval && op_legal) |=> flags_o[4] == $past(x_i)); // R12
  AST_RECORD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i |=> ($stable(flags_o) && !illegal_o)); // R13
endmodule

bind cc_eval cc_eval_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rec_valid_i(rec_valid_i),
  .eval_i     (eval_i),
  .x_i        (x_i),
  .flags_o    (flags_o),
  .illegal_o  (illegal_o),
  .op_q       (op_q)
);

// File: tb/cc_eval_test.sv
`timescale 1ns/1ps
module cc_eval_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0;
  logic [3:0]  rec_op = '0;
  logic [31:0] rec_dest = '0, rec_src = '0;
  logic        eval = 1'b0, x = 1'b0, prev_z = 1'b1;
  logic [4:0]  flags;
  logic        illegal;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cc_eval uut (
    .clk_i(clk), .rst_ni(rst_n), .rec_valid_i(rec_valid), .rec_op_i(rec_op),
    .rec_dest_i(rec_dest), .rec_src_i(rec_src), .eval_i(eval), .x_i(x),
    .prev_z_i(prev_z), .flags_o(flags), .illegal_o(illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected NZVC derived from the requirement text
  function automatic logic [3:0] model(input logic [3:0] op, input logic [31:0] d,
                                       input logic [31:0] s, input logic pz);
    logic n, z, v, c;
    logic [31:0] m, t, vv, dm, sm;
    int w;
    w = (op == 4) ? 8 : (op == 5) ? 16 : 32;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    dm = d & m; sm = s & m;
    z = (dm == 0); n = !z && dm[w-1];
    v = 0; c = 0;
    case (op)
      0: return d[3:0];
      2: begin c = d < s; t = d - s; vv = (s ^ d) & ~(t ^ s); v = vv[31]; end
      3, 4, 5: begin t = (dm + sm) & m; c = t < sm; vv = (t ^ dm) & (t ^ sm); v = vv[w-1]; end
      6: begin c = d <= s; t = d - s - 1; vv = (s ^ d) & ~(t ^ s); v = vv[31]; end
      7: begin t = d + s + 1; c = t <= s; vv = (t ^ d) & (t ^ s); v = vv[31]; end
      8: c = (s != 0);
      default: ;
    endcase
    if (op == 6 || op == 7) z = z & pz;
    return {n, z, v, c};
  endfunction

  function automatic string tag(input logic [3:0] op);
    case (op)
      1: return "R2"; 2: return "R4"; 3, 4, 5: return "R5";
      6: return "R6"; 7: return "R7"; 8: return "R8"; default: return "R11";
    endcase
  endfunction

  task automatic do_record(input logic [3:0] op, input logic [31:0] d, input logic [31:0] s);
    rec_valid = 1; rec_op = op; rec_dest = d; rec_src = s;
    @(negedge clk);
    rec_valid = 0;
  endtask

  task automatic do_eval(input logic xv, input logic pz);
    eval = 1; x = xv; prev_z = pz;
    @(negedge clk);
    eval = 0;
  endtask

  task automatic test_reset();
    chk("R1 flags", flags, 0);
    chk("R1 illegal", illegal, 0);
    do_eval(0, 1);
    chk("R1 eval after reset", flags, 0);
  endtask

  task automatic test_hand_values();
    do_record(2, 32'h0, 32'h1); do_eval(0, 1);
    chk("R4 add zero carry", flags[3:0], 4'b0101);
    do_record(3, 32'h7FFF_FFFF, 32'h1); do_eval(0, 1);
    chk("R5 sub overflow", flags[3:0], 4'b0010);
    do_record(4, 32'hFFFF_FF80, 32'h1); do_eval(0, 1);
    chk("R5 cmpb negative", flags[3:0], 4'b1000);
    do_record(4, 32'h0000_0100, 32'h0); do_eval(0, 1);
    chk("R3 byte zero", flags[3:0], 4'b0100);
    do_record(5, 32'h0001_8000, 32'h0); do_eval(0, 1);
    chk("R3 word negative", flags[3:0], 4'b1000);
    do_record(1, 32'h8000_0000, 32'h5); do_eval(0, 1);
    chk("R2 logic negative", flags[3:0], 4'b1000);
    do_record(8, 32'h0, 32'h1); do_eval(0, 1);
    chk("R8 shift carry", flags[3:0], 4'b0101);
    do_record(6, 32'h0, 32'h0); do_eval(0, 1);
    chk("R6 addx carry", flags[3:0], 4'b0101);
  endtask

  task automatic test_sweep();
    logic [31:0] lfsr = 32'hACE1_1234;
    logic [31:0] sp [10] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
                            32'h7F, 32'h80, 32'hFF, 32'h7FFF, 32'h8000};
    for (int op = 1; op <= 8; op++) begin
      for (int i = 0; i < 24; i++) begin
        logic [31:0] d, s;
        if (i < 10) begin d = sp[i]; s = sp[(i * 3 + 1) % 10]; end
        else begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; d = lfsr;
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; s = lfsr;
        end
        do_record(4'(op), d, s); do_eval(0, 1);
        chk(tag(4'(op)), flags[3:0], model(4'(op), d, s, 1));
        chk("R3 nz exclusive", flags[3] & flags[2], 0);
      end
    end
  endtask

  task automatic test_sticky_z();
    do_record(7, 32'h0, 32'h0); do_eval(0, 1);
    chk("R9 subx z kept", flags[3:0], 4'b0100);
    do_record(7, 32'h0, 32'h0); do_eval(0, 0);
    chk("R9 subx z sticky clear", flags[3:0], 4'b0000);
    do_record(6, 32'h0, 32'h0); do_eval(0, 0);
    chk("R9 addx z sticky clear", flags[3:0], 4'b0001);
    do_record(3, 32'h0, 32'h0); do_eval(0, 0);
    chk("R9 sub not sticky", flags[3:0], 4'b0100);
  endtask

  task automatic test_illegal();
    do_record(1, 32'h0, 32'h0); do_eval(1, 1);
    chk("R10 setup", flags, 5'b10100);
    for (int op = 9; op <= 15; op++) begin
      do_record(4'(op), 32'hFFFF_FFFF, 32'h1); do_eval(0, 1);
      chk("R10 illegal pulse", illegal, 1);
      chk("R10 flags held", flags, 5'b10100);
    end
    do_eval(0, 1);
    chk("R10 state unchanged", illegal, 1);
    @(negedge clk);
    chk("R10 pulse ends", illegal, 0);
  endtask

  task automatic test_pass_rewrite();
    do_record(0, 32'h0000_01F5, 32'h0); do_eval(0, 1);
    chk("R11 pass low bits", flags[3:0], 4'h5);
    do_record(3, 32'h7FFF_FFFF, 32'h1); do_eval(0, 1);
    chk("R11 first eval", flags[3:0], 4'b0010);
    do_eval(0, 0);
    chk("R11 idempotent", flags[3:0], 4'b0010);
    do_record(7, 32'h0, 32'h0); do_eval(0, 1);
    do_eval(0, 0);
    chk("R11 idempotent after subx", flags[3:0], 4'b0100);
  endtask

  task automatic test_x_and_hold();
    do_record(1, 32'h1, 32'h0); do_eval(1, 1);
    chk("R12 x set", flags, 5'b10000);
    do_eval(0, 1);
    chk("R12 x clear", flags, 5'b00000);
    do_record(1, 32'h0, 32'h0);
    @(negedge clk);
    chk("R12 hold without eval", flags, 5'b00000);
  endtask

  task automatic test_record_wins();
    do_record(1, 32'h0, 32'h0); do_eval(0, 1);
    chk("R13 setup", flags, 5'b00100);
    rec_valid = 1; rec_op = 4'd2; rec_dest = 32'h0; rec_src = 32'h1;
    eval = 1; x = 1;
    @(negedge clk);
    rec_valid = 0; eval = 0;
    chk("R13 eval dropped", flags, 5'b00100);
    chk("R13 no illegal", illegal, 0);
    do_eval(0, 1);
    chk("R13 record stored", flags, 5'b00101);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_hand_values();
    test_sweep();
    test_sticky_z();
    test_illegal();
    test_pass_rewrite();
    test_x_and_hold();
    test_record_wins();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule